// File: doc/BRIEF.md
# Prioritized Microtask Switch Controller

This block decides which of up to sixteen microcode tasks owns a shared microsequencer. Each task slot keeps its own saved microprogram counter and an awake flag. The flag is set by that task's wakeup line and cleared by that task's block line. Task 0 is the background task and is always awake. The block shows the running task's counter to the control store. When the sequencer retires a microinstruction, the block writes the next address that instruction produced back into the running task's slot.

A retiring microinstruction can carry a yield flag. The yield does not switch tasks at once. It picks the highest-numbered awake task and holds it as pending. The switch happens on the next retire that carries no yield. That retire still runs as the old task and stores its next address in the old task's slot. From the following cycle the pending task is current and its saved counter drives the control store.

Retirement is a single strobe that the controller accepts in every cycle. There is no back-pressure: the sequencer never waits on this block, and a cycle without the strobe leaves all task state as it was. A counter of retired instructions is also provided.

Top module: `utask_switch`

## Requirements
- R1: After reset, the current task is 0, nothing is pending and the retire counter is 0. Every slot's saved counter equals its own task number, so a task that becomes current before it has ever retired shows its own number on `cur_pc`.
- R2: A task's awake flag sets when its `wake_set` bit is 1 and clears when its `wake_block` bit is 1. The new flag value counts from the next cycle. When both bits are 1 in the same cycle, set wins. Bit 0 of `wake_block` is ignored, and task 0 is always awake.
- R3: A retire with `ret_task`=1 loads `pend_task` with the highest-numbered task that is awake at the start of that cycle and sets `pend_valid`. `cur_task` does not change.
- R4: A retire with `ret_task`=0 while `pend_valid`=1 makes the pending task current from the next cycle and clears `pend_valid`.
- R5: A retire with `ret_task`=1 while a task is already pending replaces the pending task with a fresh selection, and the current task stays.
- R6: Each retire writes `ret_next_pc` into the slot of the task that was current during that retire. No other slot changes.
- R7: `cur_pc` always shows the saved counter of `cur_task`.
- R8: `cycle_count` increases by one on each retire and wraps at its width.
- R9: In a cycle with `ret_valid`=0, the current task, the pending state, the saved counters and `cycle_count` all keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wake_set | input | NT | Per-task wakeup request |
| wake_block | input | NT | Per-task block request; clears the awake flag |
| ret_valid | input | 1 | A microinstruction retires this cycle |
| ret_task | input | 1 | The retiring instruction requests a task switch |
| ret_next_pc | input | PC_W | Next address produced by the retiring instruction |
| cur_task | output | TW | Index of the current task |
| cur_pc | output | PC_W | Saved counter of the current task, to the control store |
| pend_valid | output | 1 | A switch is pending |
| pend_task | output | TW | Index of the pending task |
| cycle_count | output | CW | Retired-instruction counter |

## Verification
Two collisions matter here. The first is a switch-taking retire: it writes the next address into the old task's slot in the same cycle that the current index moves to the new task. The bench checks that the old slot gets the address and that `cur_pc` then shows the new task's untouched counter. The second is a wakeup that arrives in the same cycle as a block, or in the same cycle as a yield. The bench provokes both in directed steps and then at random. It checks that set beats block, and that a yield only sees wakeups from earlier cycles. A behavioural model compares every output on every clock.

// File: rtl/utsw_pkg.sv
package utsw_pkg;
  // Sequencing decision taken for one cycle
  typedef enum logic [1:0] {
    ACT_IDLE  = 2'd0,  // no retire
    ACT_STAY  = 2'd1,  // retire, no task change
    ACT_LATCH = 2'd2,  // retire with yield: capture pending
    ACT_SWAP  = 2'd3   // retire, pending becomes current
  } utsw_act_e;
endpackage

// File: rtl/utsw_wake.sv
module utsw_wake #(
  parameter int NT = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NT-1:0] set_i,
  input  logic [NT-1:0] block_i,
  output logic [NT-1:0] awake_o
);
  logic [NT-1:0] awake_q;

  for (genvar g = 0; g < NT; g++) begin : g_slot
    if (g == 0) begin : g_bg
      // background task can never sleep
      assign awake_q[g] = 1'b1;
    end else begin : g_dev
      logic flag_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          flag_q <= 1'b0;
        else if (set_i[g])   flag_q <= 1'b1;
        else if (block_i[g]) flag_q <= 1'b0;
      end
      assign awake_q[g] = flag_q;
    end
  end

  assign awake_o = awake_q;

  logic unused_w;
  assign unused_w = &{1'b0, set_i[0], block_i[0]};
endmodule

// File: rtl/utsw_prio.sv
module utsw_prio #(
  parameter int NT = 16,
  localparam int TW = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic [NT-1:0] req_i,
  output logic [TW-1:0] win_o
);
  // highest index wins; later iterations override earlier ones
  always_comb begin
    win_o = '0;
    for (int i = 0; i < NT; i++) begin
      if (req_i[i]) win_o = TW'(i);
    end
  end
endmodule

// File: rtl/utsw_pcfile.sv
module utsw_pcfile #(
  parameter int NT   = 16,
  parameter int PC_W = 10,
  localparam int TW  = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en_i,
  input  logic [TW-1:0]   wr_idx_i,
  input  logic [PC_W-1:0] wr_pc_i,
  input  logic [TW-1:0]   rd_idx_i,
  output logic [PC_W-1:0] rd_pc_o
);
  logic [PC_W-1:0] pc_q [NT];

  for (genvar g = 0; g < NT; g++) begin : g_pc
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        pc_q[g] <= PC_W'(g);
      else if (wr_en_i && (wr_idx_i == TW'(g)))
        pc_q[g] <= wr_pc_i;
    end
  end

  assign rd_pc_o = pc_q[rd_idx_i];
endmodule

// File: rtl/utask_switch.sv
module utask_switch #(
  parameter int NT   = 16,
  parameter int PC_W = 10,
  parameter int CW   = 32,
  localparam int TW  = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NT-1:0]   wake_set,
  input  logic [NT-1:0]   wake_block,
  input  logic            ret_valid,
  input  logic            ret_task,
  input  logic [PC_W-1:0] ret_next_pc,
  output logic [TW-1:0]   cur_task,
  output logic [PC_W-1:0] cur_pc,
  output logic            pend_valid,
  output logic [TW-1:0]   pend_task,
  output logic [CW-1:0]   cycle_count
);
  import utsw_pkg::*;

  logic [NT-1:0] awake;
  logic [TW-1:0] best;
  logic [TW-1:0] cur_q, pend_q;
  logic          pv_q;
  logic [CW-1:0] cyc_q;
  utsw_act_e     act;

  utsw_wake #(.NT(NT)) u_wake (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (wake_set),
    .block_i (wake_block),
    .awake_o (awake)
  );

  utsw_prio #(.NT(NT)) u_prio (
    .req_i (awake),
    .win_o (best)
  );

  utsw_pcfile #(.NT(NT), .PC_W(PC_W)) u_pcs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en_i  (ret_valid),
    .wr_idx_i (cur_q),
    .wr_pc_i  (ret_next_pc),
    .rd_idx_i (cur_q),
    .rd_pc_o  (cur_pc)
  );

  always_comb begin
    if (!ret_valid)    act = ACT_IDLE;
    else if (ret_task) act = ACT_LATCH;
    else if (pv_q)     act = ACT_SWAP;
    else               act = ACT_STAY;
  end

  // reset selection: only the background task is awake, so it is chosen
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      pend_q <= '0;
      pv_q   <= 1'b0;
      cyc_q  <= '0;
    end else begin
      if (act != ACT_IDLE) cyc_q <= cyc_q + 1'b1;
      case (act)
        ACT_LATCH: begin
          pend_q <= best;
          pv_q   <= 1'b1;
        end
        ACT_SWAP: begin
          cur_q <= pend_q;
          pv_q  <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assign cur_task    = cur_q;
  assign pend_valid  = pv_q;
  assign pend_task   = pend_q;
  assign cycle_count = cyc_q;
endmodule

// File: rtl/utask_switch_chk.sv
module utask_switch_chk #(
  parameter int NT   = 16,
  parameter int PC_W = 10,
  parameter int CW   = 32,
  localparam int TW  = (NT > 1) ? $clog2(NT) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ret_valid,
  input logic            ret_task,
  input logic [PC_W-1:0] ret_next_pc,
  input logic [TW-1:0]   cur_task,
  input logic [PC_W-1:0] cur_pc,
  input logic            pend_valid,
  input logic [TW-1:0]   pend_task,
  input logic [CW-1:0]   cycle_count
);
  p_latch_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && ret_task) |=> (pend_valid && $stable(cur_task)));

  p_swap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !ret_task && pend_valid) |=>
      (!pend_valid && cur_task == $past(pend_task)));

  p_pc_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !(!ret_task && pend_valid)) |=> (cur_pc == $past(ret_next_pc)));

  p_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |=> (cycle_count == $past(cycle_count) + 1'b1));

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ret_valid |=> ($stable(cur_task) && $stable(pend_valid) &&
                    $stable(pend_task) && $stable(cur_pc) && $stable(cycle_count)));
endmodule

bind utask_switch utask_switch_chk #(.NT(NT), .PC_W(PC_W), .CW(CW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ret_valid   (ret_valid),
  .ret_task    (ret_task),
  .ret_next_pc (ret_next_pc),
  .cur_task    (cur_task),
  .cur_pc      (cur_pc),
  .pend_valid  (pend_valid),
  .pend_task   (pend_task),
  .cycle_count (cycle_count)
);

// File: tb/tb_utask_switch.sv
module tb_utask_switch;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 16;
  localparam int PC_W = 10;
  localparam int CW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NT-1:0] wake_set = '0, wake_block = '0;
  logic ret_valid = 1'b0, ret_task = 1'b0;
  logic [PC_W-1:0] ret_next_pc = '0;
  logic [3:0] cur_task, pend_task;
  logic [PC_W-1:0] cur_pc;
  logic pend_valid;
  logic [CW-1:0] cycle_count;

  int checks = 0, failures = 0;
  bit done = 0;

  int m_pc [NT];
  int m_wake, m_cur, m_pend, m_pv, m_cyc;

  always #(CLK_PERIOD/2) clk = ~clk;

  utask_switch #(.NT(NT), .PC_W(PC_W), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .wake_set(wake_set), .wake_block(wake_block),
    .ret_valid(ret_valid), .ret_task(ret_task), .ret_next_pc(ret_next_pc),
    .cur_task(cur_task), .cur_pc(cur_pc), .pend_valid(pend_valid),
    .pend_task(pend_task), .cycle_count(cycle_count)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int best_awake(input int w);
    int b = 0;
    for (int i = 0; i < NT; i++) if (w[i]) b = i;
    return b;
  endfunction

  task automatic compare_all();
    chk(cur_task == m_cur, "R4 cur_task", cur_task, m_cur);
    chk(pend_valid == m_pv, "R3 pend_valid", pend_valid, m_pv);
    if (m_pv) chk(pend_task == m_pend, "R3 pend_task", pend_task, m_pend);
    chk(cur_pc == m_pc[m_cur], "R6 cur_pc", cur_pc, m_pc[m_cur]);
    chk(cycle_count == m_cyc, "R8 cycle_count", cycle_count, m_cyc);
  endtask

  // drive at negedge, model at posedge, compare at next negedge
  task automatic step(input bit v, input bit t, input int npc, input int ws, input int bk);
    wake_set = NT'(ws); wake_block = NT'(bk);
    ret_valid = v; ret_task = t; ret_next_pc = PC_W'(npc);
    @(posedge clk);
    if (v) begin
      int oc = m_cur;
      if (t) begin m_pend = best_awake(m_wake); m_pv = 1; end
      else if (m_pv) begin m_cur = m_pend; m_pv = 0; end
      m_pc[oc] = npc % (1 << PC_W);
      m_cyc++;
    end
    m_wake = ((m_wake & ~bk) | ws | 1) & ((1 << NT) - 1);
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NT; i++) m_pc[i] = i;
    m_wake = 1; m_cur = 0; m_pend = 0; m_pv = 0; m_cyc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cur_task == 0, "R1 cur_task", cur_task, 0);
    chk(pend_valid == 0, "R1 pend_valid", pend_valid, 0);
    chk(cycle_count == 0, "R1 cycle_count", cycle_count, 0);
    chk(cur_pc == 0, "R1 cur_pc", cur_pc, 0);

    // R9: wakeups without retire leave task state untouched
    step(0, 0, 0, (1 << 3) | (1 << 7), 0);
    chk(cur_task == 0 && pend_valid == 0 && cycle_count == 0, "R9 idle", cycle_count, 0);
    // R3: yield picks highest awake (7); wake 12 in same cycle is not yet seen
    step(1, 1, 33, 1 << 12, 0);
    chk(pend_task == 7 && cur_task == 0, "R3 pick", pend_task, 7);
    // R4/R1/R7: swap; task 7 never ran so shows its own number
    step(1, 0, 44, 0, 0);
    chk(cur_task == 7, "R4 swap", cur_task, 7);
    chk(cur_pc == 7, "R1 R7 fresh pc", cur_pc, 7);
    chk(m_pc[0] == 44, "R6 model old slot", m_pc[0], 44);
    // R2: set and block same cycle on 12 -> stays awake; block on 0 ignored
    step(0, 0, 0, 1 << 12, (1 << 12) | 1);
    step(1, 1, 100, 0, 0);
    chk(pend_task == 12, "R2 set wins", pend_task, 12);
    // R5: block 12, yield again while pending -> reselect 7
    step(0, 0, 0, 0, 1 << 12);
    step(1, 1, 101, 0, 0);
    chk(pend_task == 7 && cur_task == 7, "R5 overwrite", pend_task, 7);
    step(1, 0, 102, 0, 0);
    chk(cur_pc == 102, "R6 self swap", cur_pc, 102);
    // R2: block all device tasks -> only background remains
    step(0, 0, 0, 0, 'hFFFF);
    step(1, 1, 5, 0, 0);
    chk(pend_task == 0, "R2 block all", pend_task, 0);
    step(1, 0, 6, 0, 0);
    chk(cur_task == 0 && cur_pc == 44, "R6 R7 return", cur_pc, 44);

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      int ws = 0, bk = 0;
      if ($urandom_range(0, 3) == 0) ws = 1 << $urandom_range(0, NT-1);
      if ($urandom_range(0, 3) == 0) bk = 1 << $urandom_range(0, NT-1);
      step($urandom_range(0, 3) != 0, $urandom_range(0, 2) == 0,
           int'($urandom_range(0, (1 << PC_W) - 1)), ws, bk);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule